// File: doc/BRIEF.md
# Serial Flash Erase, Program and Unprotect Sequencer

This block runs the multi-step maintenance operations of a serial NOR flash on its own. Each operation is a chain of commands sent through a lower-level byte transport that serializes them on the wire. A client presents one request: an operation code, a 24-bit flash address and, for a program, a data byte. The sequencer then issues the write-enable command, the operation command with its address bytes most significant first, and a run of status-register reads. It stops when the device's write-in-progress bit reads clear, or when a per-operation poll budget runs out.

A full-chip erase and a stand-alone unprotect first read the status register. If any block-protect bit is set, they send write-enable and a write-status command that clears those bits. Each operation has its own poll interval and poll limit on configuration inputs, so a chip erase that takes seconds can be polled sparsely while a byte program is polled closely.

The transport is a request/acknowledge port. The sequencer raises `xf_req` with a write count, a read count and up to five bytes. It holds them until the transport pulses `xf_ack`, which also carries the byte read back.

Top module: `flash_maint_seq`

## Requirements
- R1: A request (`req_valid` high) is taken only when `busy` is low and `req_op` is one of 0 chip erase, 1 block erase, 2 sector erase, 3 byte program, 4 unprotect. Codes 5..7, and any request while `busy` is high, cause no transfer and no `done`. `busy` goes high in the cycle after a request is taken.
- R2: Block and sector erase send write-enable (1 byte 0x06, 0 read bytes), then 4 bytes: opcode 0xD8 (block) or 0x20 (sector) followed by address bits 23:16, 15:8, 7:0.
- R3: Byte program sends write-enable, then 5 bytes: 0x02, address bits 23:16, 15:8, 7:0, then the data byte.
- R4: Chip erase first reads status (1 byte 0x05, 1 read byte). If status bits 5:2 are non-zero, it sends write-enable and then 2 bytes {0x01, status with bits 5:2 cleared}. It then sends write-enable and the single byte 0xC7.
- R5: Unprotect reads status. With bits 5:2 clear it ends with no further transfer. Otherwise it sends write-enable and the write-status command, then polls.
- R6: After the operation command, status reads (0x05, 1 read byte) repeat until the read byte has bit 0 clear. The block then pulses `done` for one cycle with `busy` low and `timeout_err` low.
- R7: Before each status poll the block waits at least gap+1 idle cycles after the previous transfer. The gap for operation k is `cfg_gap[k*16 +: 16]`.
- R8: If `cfg_lim[k*12 +: 12]` consecutive polls all read bit 0 set, the block stops issuing transfers. It pulses `done` with `timeout_err` high. `timeout_err` stays high until the next request is taken.
- R9: During and right after reset, `busy`, `done`, `timeout_err` and `xf_req` are low.
- R10: Once `xf_req` is raised, it and `xf_wcnt`, `xf_rcnt`, `xf_wdata` stay unchanged until the cycle in which `xf_ack` is seen. Byte i on the wire is `xf_wdata[8*i +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | 24 | Flash byte address |
| req_data | input | 8 | Data byte for byte program |
| cfg_gap | input | 80 | Per-operation poll gap, 16 bits per operation |
| cfg_lim | input | 60 | Per-operation poll limit, 12 bits per operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last operation ended by poll limit |
| xf_req | output | 1 | Transfer request to byte transport |
| xf_wcnt | output | 3 | Bytes to write |
| xf_rcnt | output | 2 | Bytes to read after writing |
| xf_wdata | output | 40 | Write bytes, first byte in bits 7:0 |
| xf_ack | input | 1 | Transport completion pulse |
| xf_rdata | input | 8 | Byte read back, valid with `xf_ack` |

## Verification
The bench targets the branch on block-protect bits. A design that tested the wrong bits, or skipped the write-status step, would send a bare 0xC7 to a protected part, or send a needless 0x01 to an unprotected one. Address byte order is checked with asymmetric addresses, so a reversed order shows up as a wrong byte in position 1. Poll spacing is measured with very different gaps for chip and sector erase, which exposes a swapped configuration slice. An off-by-one in the poll limit shows up as a wrong count of status reads before `timeout_err`. Requests made while busy, and undefined operation codes, must leave the transfer log and the `done` count untouched.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   localparam int NUM_OPS = 5;

   typedef enum logic [2:0] {
      OP_CHIP   = 3'd0,
      OP_BLOCK  = 3'd1,
      OP_SECTOR = 3'd2,
      OP_PROG   = 3'd3,
      OP_UNPROT = 3'd4
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PSTAT, ST_PWEN, ST_PWRS, ST_WEN, ST_CMD, ST_GAP, ST_POLL
   } step_e;

   localparam logic [7:0] OPC_WREN = 8'h06;
   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam logic [7:0] OPC_WRSR = 8'h01;
   localparam logic [7:0] OPC_CE   = 8'hC7;
   localparam logic [7:0] OPC_BE   = 8'hD8;
   localparam logic [7:0] OPC_SE   = 8'h20;
   localparam logic [7:0] OPC_PP   = 8'h02;
endpackage

// File: rtl/flash_seq_cmdfmt.sv
module flash_seq_cmdfmt
   import flash_seq_pkg::*;
#(
   parameter logic [7:0] PROT_MASK = 8'h3C
)(
   input  step_e       step,
   input  op_e         op,
   input  logic [23:0] addr,
   input  logic [7:0]  data,
   input  logic [7:0]  stat,
   output logic [2:0]  wcnt,
   output logic [1:0]  rcnt,
   output logic [39:0] wbytes
);
   always_comb begin
      wcnt   = 3'd0;
      rcnt   = 2'd0;
      wbytes = '0;
      case (step)
         ST_PSTAT, ST_POLL: begin
            wcnt = 3'd1; rcnt = 2'd1; wbytes[7:0] = OPC_RDSR;
         end
         ST_PWEN, ST_WEN: begin
            wcnt = 3'd1; wbytes[7:0] = OPC_WREN;
         end
         ST_PWRS: begin
            wcnt = 3'd2; wbytes[15:0] = {stat & ~PROT_MASK, OPC_WRSR};
         end
         ST_CMD: begin
            case (op)
               OP_CHIP: begin
                  wcnt = 3'd1; wbytes[7:0] = OPC_CE;
               end
               OP_BLOCK, OP_SECTOR: begin
                  wcnt = 3'd4;
                  wbytes[31:0] = {addr[7:0], addr[15:8], addr[23:16],
                                  (op == OP_BLOCK) ? OPC_BE : OPC_SE};
               end
               OP_PROG: begin
                  wcnt = 3'd5;
                  wbytes = {data, addr[7:0], addr[15:8], addr[23:16], OPC_PP};
               end
               default: ;
            endcase
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/flash_seq_pace.sv
module flash_seq_pace #(
   parameter int GAP_W = 16,
   parameter int LIM_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic             poll_ack,
   input  logic [GAP_W-1:0] gap,
   input  logic [LIM_W-1:0] lim,
   output logic             gap_done,
   output logic             exhausted
);
   logic [GAP_W-1:0] gcnt;
   logic [LIM_W-1:0] pcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gcnt <= '0;
      else if (load) gcnt <= gap;
      else if (gcnt != '0) gcnt <= gcnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcnt <= '0;
      else if (clear) pcnt <= '0;
      else if (poll_ack && (pcnt != '1)) pcnt <= pcnt + 1'b1;
   end

   assign gap_done  = (gcnt == '0);
   assign exhausted = (({1'b0, pcnt} + 1'b1) >= {1'b0, lim});
endmodule

// File: rtl/flash_maint_seq.sv
module flash_maint_seq
   import flash_seq_pkg::*;
#(
   parameter int         GAP_W     = 16,
   parameter int         LIM_W     = 12,
   parameter logic [7:0] PROT_MASK = 8'h3C,
   parameter int         WIP_BIT   = 0
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [2:0]                 req_op,
   input  logic [23:0]                req_addr,
   input  logic [7:0]                 req_data,
   input  logic [NUM_OPS*GAP_W-1:0]   cfg_gap,
   input  logic [NUM_OPS*LIM_W-1:0]   cfg_lim,
   output logic                       busy,
   output logic                       done,
   output logic                       timeout_err,
   output logic                       xf_req,
   output logic [2:0]                 xf_wcnt,
   output logic [1:0]                 xf_rcnt,
   output logic [39:0]                xf_wdata,
   input  logic                       xf_ack,
   input  logic [7:0]                 xf_rdata
);
   if (GAP_W < 1 || GAP_W > 32) begin : g_bad_gap_w
      $error("GAP_W out of range");
   end
   if (LIM_W < 1 || LIM_W > 32) begin : g_bad_lim_w
      $error("LIM_W out of range");
   end
   if (WIP_BIT < 0 || WIP_BIT > 7) begin : g_bad_wip
      $error("WIP_BIT out of range");
   end else if (PROT_MASK[WIP_BIT]) begin : g_bad_mask
      $error("PROT_MASK overlaps busy bit");
   end

   // per-operation configuration slices
   logic [GAP_W-1:0] gap_tab [NUM_OPS];
   logic [LIM_W-1:0] lim_tab [NUM_OPS];
   for (genvar k = 0; k < NUM_OPS; k++) begin : g_cfg
      assign gap_tab[k] = cfg_gap[k*GAP_W +: GAP_W];
      assign lim_tab[k] = cfg_lim[k*LIM_W +: LIM_W];
   end

   step_e       st, st_nx;
   op_e         op_q;
   logic [23:0] addr_q;
   logic [7:0]  data_q, stat_q;
   logic        accept, fin, tmo_set, load, gap_done, exhausted, poll_ack;
   logic [GAP_W-1:0] gap_sel;
   logic [LIM_W-1:0] lim_sel;

   assign accept   = (st == ST_IDLE) && req_valid && (req_op < 3'(NUM_OPS));
   assign poll_ack = (st == ST_POLL) && xf_ack;
   assign gap_sel  = gap_tab[op_q];
   assign lim_sel  = lim_tab[op_q];
   assign busy     = (st != ST_IDLE);
   assign xf_req   = (st != ST_IDLE) && (st != ST_GAP);

   always_comb begin
      st_nx   = st;
      fin     = 1'b0;
      tmo_set = 1'b0;
      load    = 1'b0;
      case (st)
         ST_IDLE:
            if (accept)
               st_nx = (op_e'(req_op) == OP_CHIP || op_e'(req_op) == OP_UNPROT)
                       ? ST_PSTAT : ST_WEN;
         ST_PSTAT:
            if (xf_ack) begin
               if ((xf_rdata & PROT_MASK) != 8'h00) st_nx = ST_PWEN;
               else if (op_q == OP_UNPROT)          fin   = 1'b1;
               else                                 st_nx = ST_WEN;
            end
         ST_PWEN:
            if (xf_ack) st_nx = ST_PWRS;
         ST_PWRS:
            if (xf_ack) begin
               if (op_q == OP_UNPROT) begin st_nx = ST_GAP; load = 1'b1; end
               else st_nx = ST_WEN;
            end
         ST_WEN:
            if (xf_ack) st_nx = ST_CMD;
         ST_CMD:
            if (xf_ack) begin st_nx = ST_GAP; load = 1'b1; end
         ST_GAP:
            if (gap_done) st_nx = ST_POLL;
         ST_POLL:
            if (xf_ack) begin
               if (!xf_rdata[WIP_BIT]) fin = 1'b1;
               else if (exhausted) begin fin = 1'b1; tmo_set = 1'b1; end
               else begin st_nx = ST_GAP; load = 1'b1; end
            end
         default: st_nx = ST_IDLE;
      endcase
      if (fin) st_nx = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         op_q        <= OP_CHIP;
         addr_q      <= '0;
         data_q      <= '0;
         stat_q      <= '0;
         done        <= 1'b0;
         timeout_err <= 1'b0;
      end else begin
         st   <= st_nx;
         done <= fin;
         if (accept) begin
            op_q        <= op_e'(req_op);
            addr_q      <= req_addr;
            data_q      <= req_data;
            timeout_err <= 1'b0;
         end else if (tmo_set) begin
            timeout_err <= 1'b1;
         end
         if (st == ST_PSTAT && xf_ack) stat_q <= xf_rdata;
      end
   end

   flash_seq_cmdfmt #(.PROT_MASK(PROT_MASK)) u_fmt (
      .step(st), .op(op_q), .addr(addr_q), .data(data_q), .stat(stat_q),
      .wcnt(xf_wcnt), .rcnt(xf_rcnt), .wbytes(xf_wdata)
   );

   flash_seq_pace #(.GAP_W(GAP_W), .LIM_W(LIM_W)) u_pace (
      .clk(clk), .rst_n(rst_n), .clear(accept), .load(load),
      .poll_ack(poll_ack), .gap(gap_sel), .lim(lim_sel),
      .gap_done(gap_done), .exhausted(exhausted)
   );
endmodule

// File: rtl/flash_maint_seq_chk.sv
module flash_maint_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [2:0]  req_op,
   input logic        busy,
   input logic        done,
   input logic        timeout_err,
   input logic        xf_req,
   input logic [2:0]  xf_wcnt,
   input logic [1:0]  xf_rcnt,
   input logic [39:0] xf_wdata,
   input logic        xf_ack
);
   // R9: quiet outputs while reset is applied
   always @(posedge clk)
      if (!rst_n)
         p_reset_state_r9: assert (!busy && !done && !timeout_err && !xf_req);

   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && (req_op < 3'd5)) |=> busy);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !xf_req);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xf_req && !xf_ack) |=> (xf_req && $stable(xf_wdata) &&
                               $stable(xf_wcnt) && $stable(xf_rcnt)));

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !xf_req));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_tmo_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_err) |-> done);
endmodule

bind flash_maint_seq flash_maint_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .busy(busy), .done(done), .timeout_err(timeout_err), .xf_req(xf_req),
   .xf_wcnt(xf_wcnt), .xf_rcnt(xf_rcnt), .xf_wdata(xf_wdata), .xf_ack(xf_ack)
);

// File: tb/flash_maint_seq_test.sv
module flash_maint_seq_test;
   import flash_seq_pkg::*;
   localparam int GW = 16, LW = 12, LAT = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, req_valid, busy, done, timeout_err, xf_req, xf_ack;
   logic [2:0] req_op, xf_wcnt;
   logic [1:0] xf_rcnt;
   logic [23:0] req_addr;
   logic [7:0] req_data, xf_rdata;
   logic [39:0] xf_wdata;
   logic [NUM_OPS*GW-1:0] cfg_gap;
   logic [NUM_OPS*LW-1:0] cfg_lim;

   flash_maint_seq uut (.*);

   int cyc = 0;
   always @(posedge clk) cyc++;

   int n_chk = 0, n_fail = 0;
   logic [39:0] lg_b [64];
   int lg_w [64], lg_r [64], lg_t [64];
   int n_log = 0;
   logic [7:0] sreg;
   int busy_left = 0, cfg_busy = 0;
   logic [39:0] hb;
   logic got_done, got_tmo;

   task automatic chk(input bit ok, input string r, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   // transport and flash model
   initial begin
      xf_ack = 1'b0; xf_rdata = 8'h00; sreg = 8'h00;
      forever begin
         @(negedge clk);
         xf_ack = 1'b0;
         if (rst_n && xf_req) begin
            hb = xf_wdata;
            if (n_log < 64) begin
               lg_b[n_log] = xf_wdata; lg_w[n_log] = int'(xf_wcnt);
               lg_r[n_log] = int'(xf_rcnt); lg_t[n_log] = cyc;
            end
            n_log++;
            case (xf_wdata[7:0])
               8'h05: begin
                  xf_rdata = {sreg[7:1], busy_left != 0};
                  if (busy_left > 0) busy_left--;
               end
               8'h01: sreg = {xf_wdata[15:9], 1'b0};
               8'hC7, 8'hD8, 8'h20, 8'h02: busy_left = cfg_busy;
               default: ;
            endcase
            for (int k = 0; k < LAT; k++) begin
               @(negedge clk);
               chk(xf_req && xf_wdata == hb, "R10 hold", xf_wdata, hb);
            end
            xf_ack = 1'b1;
         end
      end
   end

   task automatic set_cfg(input int op, input int g, input int l);
      cfg_gap[op*GW +: GW] = GW'(g);
      cfg_lim[op*LW +: LW] = LW'(l);
   endtask

   task automatic do_op(input int op, input logic [23:0] a, input logic [7:0] d);
      n_log = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      got_done = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) begin got_done = 1'b1; break; end
      end
      got_tmo = timeout_err;
      chk(got_done, "R6 done seen", got_done, 1);
   endtask

   task automatic chk_ent(input int i, input int w, input logic [39:0] b, input string r);
      chk(lg_w[i] == w, r, lg_w[i], w);
      chk(lg_b[i] == b, r, lg_b[i], b);
      chk(lg_r[i] == ((b[7:0] == 8'h05) ? 1 : 0), r, lg_r[i], (b[7:0] == 8'h05) ? 1 : 0);
   endtask

   task automatic t_reset;
      chk(!busy && !done && !timeout_err && !xf_req, "R9 reset state",
          {busy, done, timeout_err, xf_req}, 0);
   endtask

   task automatic t_sector;
      cfg_busy = 2;
      do_op(2, 24'h123456, 8'h00);
      chk(n_log == 5, "R2 sector count", n_log, 5);
      chk_ent(0, 1, 40'h06, "R2 wren");
      chk_ent(1, 4, 40'h56341220, "R2 sector cmd");
      for (int i = 2; i < 5; i++) chk_ent(i, 1, 40'h05, "R6 poll");
      chk(!got_tmo, "R6 no timeout", got_tmo, 0);
   endtask

   task automatic t_block;
      cfg_busy = 0;
      do_op(1, 24'hABCDEF, 8'h00);
      chk(n_log == 3, "R2 block count", n_log, 3);
      chk_ent(1, 4, 40'hEFCDABD8, "R2 block cmd");
      chk_ent(2, 1, 40'h05, "R6 single poll");
   endtask

   task automatic t_program;
      cfg_busy = 1;
      do_op(3, 24'h00FF01, 8'h5A);
      chk(n_log == 4, "R3 program count", n_log, 4);
      chk_ent(0, 1, 40'h06, "R3 wren");
      chk_ent(1, 5, 40'h5A01FF0002, "R3 program cmd");
   endtask

   task automatic t_chip_prot;
      sreg = 8'h9C; cfg_busy = 1;
      do_op(0, 24'h0, 8'h00);
      chk(n_log == 7, "R4 protected chip count", n_log, 7);
      chk_ent(0, 1, 40'h05, "R4 status first");
      chk_ent(1, 1, 40'h06, "R4 wren before wrsr");
      chk_ent(2, 2, 40'h8001, "R4 wrsr clears 5:2");
      chk_ent(3, 1, 40'h06, "R4 wren before erase");
      chk_ent(4, 1, 40'hC7, "R4 chip erase");
      chk(sreg == 8'h80, "R4 device protection cleared", sreg, 8'h80);
   endtask

   task automatic t_chip_clear;
      sreg = 8'h80; cfg_busy = 0;
      do_op(0, 24'h0, 8'h00);
      chk(n_log == 4, "R4 unprotected chip count", n_log, 4);
      chk_ent(1, 1, 40'h06, "R4 no wrsr");
      chk_ent(2, 1, 40'hC7, "R4 chip erase");
   endtask

   task automatic t_unprot;
      sreg = 8'h00;
      do_op(4, 24'h0, 8'h00);
      chk(n_log == 1, "R5 nothing protected", n_log, 1);
      sreg = 8'h3C; cfg_busy = 0;
      do_op(4, 24'h0, 8'h00);
      chk(n_log == 4, "R5 protected count", n_log, 4);
      chk_ent(2, 2, 40'h0001, "R5 wrsr");
      chk_ent(3, 1, 40'h05, "R5 poll");
      chk(sreg == 8'h00, "R5 bits cleared", sreg, 0);
   endtask

   task automatic t_gap;
      set_cfg(0, 40, 20); set_cfg(2, 3, 20);
      sreg = 8'h00; cfg_busy = 2;
      do_op(0, 24'h0, 8'h00);
      chk(n_log == 6, "R7 chip count", n_log, 6);
      chk(lg_t[3] - lg_t[2] >= 41, "R7 chip first gap", lg_t[3] - lg_t[2], 41);
      chk(lg_t[4] - lg_t[3] >= 41 && lg_t[4] - lg_t[3] <= 46, "R7 chip gap",
          lg_t[4] - lg_t[3], 44);
      cfg_busy = 2;
      do_op(2, 24'h000100, 8'h00);
      chk(lg_t[3] - lg_t[2] >= 4 && lg_t[3] - lg_t[2] <= 9, "R7 sector gap",
          lg_t[3] - lg_t[2], 7);
      set_cfg(0, 2, 20); set_cfg(2, 2, 20);
   endtask

   task automatic t_timeout;
      set_cfg(2, 2, 4); cfg_busy = 100;
      do_op(2, 24'h010203, 8'h00);
      repeat (20) @(negedge clk);
      chk(n_log == 6, "R8 poll count at limit", n_log, 6);
      chk(got_tmo, "R8 timeout flag", got_tmo, 1);
      chk(timeout_err, "R8 flag held", timeout_err, 1);
      busy_left = 0; cfg_busy = 0; set_cfg(2, 2, 20);
      do_op(1, 24'h0, 8'h00);
      chk(!got_tmo, "R8 flag cleared by next request", got_tmo, 0);
   endtask

   task automatic t_ignore;
      int dn;
      n_log = 0; dn = 0;
      @(negedge clk); req_valid = 1'b1; req_op = 3'd6;
      @(negedge clk); req_valid = 1'b0;
      repeat (10) begin @(negedge clk); if (done) dn++; end
      chk(!busy && n_log == 0 && dn == 0, "R1 undefined code ignored", n_log + dn, 0);
      cfg_busy = 3; n_log = 0; dn = 0;
      @(negedge clk); req_valid = 1'b1; req_op = 3'd2; req_addr = 24'h0A0B0C;
      @(negedge clk); req_valid = 1'b1; req_op = 3'd3; req_addr = 24'hFFFFFF;
      chk(busy, "R1 busy after accept", busy, 1);
      @(negedge clk); @(negedge clk); req_valid = 1'b0;
      repeat (200) begin @(negedge clk); if (done) dn++; end
      chk(dn == 1, "R1 single done", dn, 1);
      chk(n_log == 6, "R1 busy request ignored", n_log, 6);
      chk_ent(1, 4, 40'h0C0B0A20, "R1 original op kept");
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b1; req_valid = 1'b0; req_op = 3'd0; req_addr = '0; req_data = '0;
      cfg_gap = '0; cfg_lim = '0;
      for (int k = 0; k < NUM_OPS; k++) set_cfg(k, 2, 20);
      #2 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sector();
      t_block();
      t_program();
      t_chip_prot();
      t_chip_clear();
      t_unprot();
      t_gap();
      t_timeout();
      t_ignore();
      finish_run();
   end
endmodule